// File: doc/BRIEF.md
# One-Time-Programmable Byte Array Programming Controller

This block is the programming-side control logic for a byte-wide one-time-programmable array that has one extra configuration byte beyond its data space. A device programmer drives a few strobes, an address and a data byte. On each clock edge the controller decodes those strobes into one of these operations: write a byte, read the stored byte back for comparison, test a location for the erased state, or do nothing. The array is a behavioural model. Its cells start at 0, and a write can only set bits.

The most significant address bits share pins with other functions, so they are not taken straight from the bus. A latch strobe captures them from the shared pins into a holding register, and every later operation uses that register together with the direct address lines. When the top bit of the full address is set, the operation goes to the configuration byte instead of the data array. Bit 0 of that byte chooses the output-enable style of the finished part and is also brought out as a port. A programming-enable input stands in for the high programming voltage. An erase input returns the whole model to the blank state in one cycle.

Top module: `eprom_prog_ctrl`

## Requirements
- R1: After reset, `rdata` is 0, `drive_en` is 0, `vfy_mismatch` is 0, `sync_mode` is 0, and every data location and the configuration byte read as 0.
- R2: On any clock edge where `lat_stb` is 1, the holding register loads `addr_shared`. On every other edge it keeps its value. Operations use the full address {holding register, `addr_direct`}, and the holding register forms the upper bits.
- R3: Program mode is `prog_en`=1, `pgm_stb`=1, `vfy_stb`=0, `erase`=0. It ORs `wdata` into the addressed byte. In the cycle after it, `drive_en` is 0.
- R4: Verify mode is `prog_en`=1, `vfy_stb`=1, `pgm_stb`=0. In the cycle after it, `drive_en` is 1 and `rdata` holds the stored byte.
- R5: Blank-check mode is `prog_en`=1 with both strobes at 1. It writes nothing. In the cycle after it, `drive_en` is 1 and `rdata` holds the stored byte, which is 0x00 for an erased location.
- R6: With both strobes at 0, the next cycle shows `drive_en`=0 and `rdata`=0, and the array is not changed.
- R7: While `prog_en` is 0, no strobe combination writes the array, and the next cycle shows `drive_en`=0.
- R8: Programming never clears a bit. Writing 0 over a programmed 1 leaves the 1 in place.
- R9: Each program operation records its address and data as the expected value. A verify of that same address raises `vfy_mismatch` in the next cycle if the stored byte differs from the expected value. Every other operation leaves `vfy_mismatch` at 0 in the next cycle.
- R10: A full address with its top bit (bit ADDR_W) set selects the configuration byte, whatever the lower bits hold. Program, verify and blank check act on it exactly as on a data byte.
- R11: `sync_mode` always equals bit 0 of the configuration byte: 1 for a synchronous output enable, 0 for an asynchronous one.
- R12: `erase`=1 takes priority over every other input. After that edge, all data bytes and the configuration byte are 0, the recorded expected value is dropped, and `drive_en`, `rdata` and `vfy_mismatch` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_en | input | 1 | Programming enable (stands in for the supervoltage) |
| erase | input | 1 | Clears the whole array and the configuration byte |
| lat_stb | input | 1 | Captures the upper address bits from the shared pins |
| pgm_stb | input | 1 | Program strobe, active high |
| vfy_stb | input | 1 | Verify strobe, active high |
| addr_direct | input | ADDR_W+1-HI_W | Lower address bits |
| addr_shared | input | HI_W | Shared pins that carry the upper address bits |
| wdata | input | DATA_W | Byte to program |
| rdata | output | DATA_W | Byte read back |
| drive_en | output | 1 | Data pins are driven |
| vfy_mismatch | output | 1 | Verified byte differs from the last programmed value |
| sync_mode | output | 1 | Output-enable style taken from the configuration byte |

## Verification
The bench builds the block with ADDR_W=6 and HI_W=2. This gives a 64-byte data array: five direct address lines and two latched ones, with the configuration byte at full address 64. With these values, a single test can reach the latch-dependent upper half of the data space, the configuration byte, and an alias of it at address 65. It can also reach both ends of the erase sweep.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_WRITE  = 3'd1,
      OP_VERIFY = 3'd2,
      OP_BLANK  = 3'd3,
      OP_CLEAR  = 3'd4
   } prog_op_e;
endpackage

// File: rtl/eprom_addr_hold.sv
module eprom_addr_hold #(
   parameter int HI_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lat_stb,
   input  logic [HI_W-1:0] addr_shared,
   output logic [HI_W-1:0] hi_q
);
   generate
      if (HI_W < 1) begin : g_bad_hi
         $error("HI_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       hi_q <= '0;
      else if (lat_stb) hi_q <= addr_shared;
   end

   // R2: holding register changes only under the latch strobe
   assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_stb |=> $stable(hi_q));
endmodule

// File: rtl/eprom_op_decode.sv
module eprom_op_decode
   import eprom_prog_pkg::*;
(
   input  logic     prog_en,
   input  logic     erase,
   input  logic     pgm_stb,
   input  logic     vfy_stb,
   output prog_op_e op
);
   always_comb begin
      if (erase)         op = OP_CLEAR;
      else if (!prog_en) op = OP_IDLE;
      else begin
         unique case ({pgm_stb, vfy_stb})
            2'b10:   op = OP_WRITE;
            2'b01:   op = OP_VERIFY;
            2'b11:   op = OP_BLANK;
            default: op = OP_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 10,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_en,
   input  logic [ADDR_W:0]   addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] cfg_word
);
   logic [DATA_W-1:0] cells [DEPTH];
   logic [DATA_W-1:0] cfg_q;
   logic              sel_cfg;
   logic [ADDR_W-1:0] row;

   assign sel_cfg  = addr[ADDR_W];
   assign row      = addr[ADDR_W-1:0];
   assign rd_word  = sel_cfg ? cfg_q : cells[row];
   assign cfg_word = cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
         cfg_q <= '0;
      end else if (wr_en) begin
         if (sel_cfg) cfg_q      <= cfg_q | wdata;
         else         cells[row] <= cells[row] | wdata;
      end
   end

   // R8: a write on a held address keeps every bit that was already set
   assert_bits_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clear) |=>
         ((addr != $past(addr)) || ((rd_word & $past(rd_word)) == $past(rd_word))));
endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
   import eprom_prog_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 10,
   parameter int HI_W   = 2,
   localparam int LO_W  = ADDR_W + 1 - HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic              erase,
   input  logic              lat_stb,
   input  logic              pgm_stb,
   input  logic              vfy_stb,
   input  logic [LO_W-1:0]   addr_direct,
   input  logic [HI_W-1:0]   addr_shared,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              drive_en,
   output logic              vfy_mismatch,
   output logic              sync_mode
);
   generate
      if (HI_W > ADDR_W) begin : g_bad_split
         $error("HI_W must not exceed ADDR_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic [HI_W-1:0]   hi_q;
   logic [ADDR_W:0]   full_addr;
   prog_op_e          op;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] cfg_word;
   logic              exp_valid;
   logic [ADDR_W:0]   exp_addr;
   logic [DATA_W-1:0] exp_data;

   assign full_addr = {hi_q, addr_direct};
   assign sync_mode = cfg_word[0];

   eprom_addr_hold #(.HI_W(HI_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .lat_stb(lat_stb),
      .addr_shared(addr_shared), .hi_q(hi_q)
   );

   eprom_op_decode u_dec (
      .prog_en(prog_en), .erase(erase), .pgm_stb(pgm_stb),
      .vfy_stb(vfy_stb), .op(op)
   );

   eprom_cell_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
      .clk(clk), .rst_n(rst_n), .clear(op == OP_CLEAR),
      .wr_en(op == OP_WRITE), .addr(full_addr), .wdata(wdata),
      .rd_word(rd_word), .cfg_word(cfg_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata        <= '0;
         drive_en     <= 1'b0;
         vfy_mismatch <= 1'b0;
         exp_valid    <= 1'b0;
         exp_addr     <= '0;
         exp_data     <= '0;
      end else begin
         rdata        <= '0;
         drive_en     <= 1'b0;
         vfy_mismatch <= 1'b0;
         unique case (op)
            OP_CLEAR: exp_valid <= 1'b0;
            OP_WRITE: begin
               exp_valid <= 1'b1;
               exp_addr  <= full_addr;
               exp_data  <= wdata;
            end
            OP_VERIFY: begin
               rdata        <= rd_word;
               drive_en     <= 1'b1;
               vfy_mismatch <= exp_valid && (exp_addr == full_addr) &&
                               (rd_word != exp_data);
            end
            OP_BLANK: begin
               rdata    <= rd_word;
               drive_en <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   // R7: no drive while programming is disabled
   assert_locked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_en |=> !drive_en);
   // R4: a verify cycle drives the pins next cycle
   assert_verify_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_en && !erase && vfy_stb && !pgm_stb) |=> drive_en);
   // R6: no strobe gives released, zeroed outputs
   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pgm_stb && !vfy_stb) |=> (!drive_en && rdata == '0));
   // R12: erase clears the mode bit and the mismatch flag
   assert_erase_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (!sync_mode && !vfy_mismatch && !drive_en));
   // R9: a mismatch only follows a verify
   assert_mismatch_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      vfy_mismatch |-> $past(vfy_stb && !pgm_stb && prog_en && !erase));
endmodule

// File: tb/eprom_prog_ctrl_tb.sv
`timescale 1ns/1ps
module eprom_prog_ctrl_tb;
   localparam int DW = 8;
   localparam int AW = 6;
   localparam int HW = 2;
   localparam int LW = AW + 1 - HW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prog_en = 1'b1, erase = 1'b0, lat_stb = 1'b0, pgm_stb = 1'b0, vfy_stb = 1'b0;
   logic [LW-1:0] addr_direct = '0;
   logic [HW-1:0] addr_shared = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic drive_en, vfy_mismatch, sync_mode;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   eprom_prog_ctrl #(.DATA_W(DW), .ADDR_W(AW), .HI_W(HW)) u_dut (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .erase(erase),
      .lat_stb(lat_stb), .pgm_stb(pgm_stb), .vfy_stb(vfy_stb),
      .addr_direct(addr_direct), .addr_shared(addr_shared), .wdata(wdata),
      .rdata(rdata), .drive_en(drive_en), .vfy_mismatch(vfy_mismatch),
      .sync_mode(sync_mode)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic set_addr(input logic [AW:0] a);
      @(negedge clk);
      lat_stb = 1'b1; addr_shared = a[AW:LW]; addr_direct = a[LW-1:0];
      @(negedge clk);
      lat_stb = 1'b0;
   endtask

   task automatic do_op(input logic p, input logic v, input logic [DW-1:0] d);
      @(negedge clk);
      pgm_stb = p; vfy_stb = v; wdata = d;
      @(negedge clk);
      pgm_stb = 1'b0; vfy_stb = 1'b0;
   endtask

   task automatic verify_at(input string tag, input logic [AW:0] a, input logic [DW-1:0] exp);
      set_addr(a);
      do_op(1'b0, 1'b1, 8'h00);
      check({tag, " drive"}, drive_en, 1);
      check({tag, " data"}, rdata, exp);
   endtask

   task automatic t_reset;
      check("R1 rdata", rdata, 0);
      check("R1 drive_en", drive_en, 0);
      check("R1 mismatch", vfy_mismatch, 0);
      check("R1 sync_mode", sync_mode, 0);
      verify_at("R1 blank cell 63", 7'd63, 8'h00);
      verify_at("R1 blank config", 7'd64, 8'h00);
   endtask

   task automatic t_program_verify;
      set_addr(7'h03);
      do_op(1'b1, 1'b0, 8'hA5);
      check("R3 no drive after program", drive_en, 0);
      verify_at("R4 cell 03", 7'h03, 8'hA5);
      check("R4 no mismatch", vfy_mismatch, 0);
      set_addr(7'h3E);
      do_op(1'b1, 1'b0, 8'h3C);
      verify_at("R3 cell 3E", 7'h3E, 8'h3C);
   endtask

   task automatic t_latch;
      set_addr(7'h25);
      do_op(1'b1, 1'b0, 8'h11);
      @(negedge clk);
      addr_shared = 2'b11; addr_direct = 5'h05;
      do_op(1'b0, 1'b1, 8'h00);
      check("R2 held upper bits", rdata, 8'h11);
      verify_at("R2 relatched 05", 7'h05, 8'h00);
   endtask

   task automatic t_blank;
      set_addr(7'h10);
      do_op(1'b1, 1'b1, 8'hFF);
      check("R5 erased drive", drive_en, 1);
      check("R5 erased zero", rdata, 8'h00);
      verify_at("R5 no write", 7'h10, 8'h00);
      set_addr(7'h03);
      do_op(1'b1, 1'b1, 8'hFF);
      check("R5 programmed cell", rdata, 8'hA5);
   endtask

   task automatic t_inhibit;
      set_addr(7'h07);
      do_op(1'b0, 1'b0, 8'hFF);
      check("R6 drive", drive_en, 0);
      check("R6 rdata", rdata, 0);
      verify_at("R6 array unchanged", 7'h07, 8'h00);
   endtask

   task automatic t_locked;
      prog_en = 1'b0;
      set_addr(7'h08);
      do_op(1'b1, 1'b0, 8'h77);
      check("R7 drive after pgm", drive_en, 0);
      do_op(1'b0, 1'b1, 8'h00);
      check("R7 drive after vfy", drive_en, 0);
      check("R7 rdata", rdata, 0);
      prog_en = 1'b1;
      verify_at("R7 no write", 7'h08, 8'h00);
   endtask

   task automatic t_monotonic;
      set_addr(7'h0A);
      do_op(1'b1, 1'b0, 8'hF0);
      do_op(1'b1, 1'b0, 8'h0F);
      do_op(1'b0, 1'b1, 8'h00);
      check("R8 bits kept", rdata, 8'hFF);
      check("R9 mismatch raised", vfy_mismatch, 1);
      @(negedge clk);
      check("R9 mismatch drops", vfy_mismatch, 0);
      set_addr(7'h0B);
      do_op(1'b1, 1'b0, 8'h55);
      do_op(1'b0, 1'b1, 8'h00);
      check("R9 clean verify", vfy_mismatch, 0);
   endtask

   task automatic t_config;
      check("R11 async before", sync_mode, 0);
      set_addr(7'd64);
      do_op(1'b1, 1'b0, 8'h01);
      check("R11 sync after program", sync_mode, 1);
      verify_at("R10 config byte", 7'd64, 8'h01);
      verify_at("R10 config alias", 7'd65, 8'h01);
      verify_at("R10 cell 0 untouched", 7'd0, 8'h00);
   endtask

   task automatic t_erase;
      set_addr(7'h03);
      @(negedge clk);
      erase = 1'b1; pgm_stb = 1'b1; vfy_stb = 1'b1; wdata = 8'hFF;
      @(negedge clk);
      erase = 1'b0; pgm_stb = 1'b0; vfy_stb = 1'b0;
      check("R12 sync cleared", sync_mode, 0);
      check("R12 drive", drive_en, 0);
      check("R12 mismatch", vfy_mismatch, 0);
      verify_at("R12 cell 03", 7'h03, 8'h00);
      verify_at("R12 cell 3E", 7'h3E, 8'h00);
      verify_at("R12 config", 7'd64, 8'h00);
      verify_at("R12 cell 0B", 7'h0B, 8'h00);
      check("R12 expected dropped", vfy_mismatch, 0);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program_verify();
      t_latch();
      t_blank();
      t_inhibit();
      t_locked();
      t_monotonic();
      t_config();
      t_erase();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule